// File: doc/BRIEF.md
# Trap entry unit

This block sits beside the fetch stage of a processor core and steers it into a handler whenever a trap is accepted. A trap is either an external interrupt, chosen from a bank of level-sensitive lines, or a synchronous exception signalled by a one-cycle strobe with a 6-bit cause code and a 9-bit subcode. In the cycle of acceptance the block raises `trap_taken_o` and presents the handler address on `next_pc_o`. Otherwise `next_pc_o` passes `pc_i` through, except in the first cycle after reset, when it presents the boot address.

The block owns the control state that trap entry changes. This state covers the current mode (privilege level, interrupt enable, direct-address and paged flags) and the previous mode. It also covers the return address, the faulting address, the faulting instruction, the cause and subcode, and the pending interrupt bits. There is a separate previous-mode and return register for translation-refill traps, and a debug state with its own return register. Handler addresses are an entry base plus a cause index times a programmable spacing. Interrupts use an index of a fixed base plus the line number. Refill traps jump to their own entry register. Debug traps go to the entry base plus 0x480.

A small control write port loads the current mode, the configuration (spacing field and interrupt enable mask), the entry base and the refill entry. Instructions that return from a trap are outside this block.

Cause codes (6 bits): 0x00 interrupt class, 0x03 fetch page invalid, 0x08 fetch address error, 0x0B system call, 0x0C break, 0x0D illegal instruction, 0x0E privilege error, 0x0F FP disabled, 0x10 vector unit disabled, 0x12 FP exception, 0x1A debug breakpoint. Any other code is a generic exception.

Top module: `trap_entry_unit`

## Requirements
- R1: The pending register takes the level of every interrupt line at each clock edge, so `pending_o` equals the lines of the previous cycle. `hw_irq_req_o` is 1 whenever any pending bit is 1. Both are 0 after reset.
- R2: An interrupt is accepted only when all four conditions hold: the current interrupt enable is 1, the debug state is 0, pending AND enable-mask is nonzero, and no exception strobe is present in that cycle. A strobed exception always wins over an interrupt.
- R3: For an accepted interrupt, the highest-numbered bit set in pending AND mask gives the vector v. The handler is base + (EXT_INT_BASE + v) * spacing, with EXT_INT_BASE defaulting to 64. The recorded cause is 0 and the subcode is 0.
- R4: The spacing is 4 << VS bytes when the 3-bit spacing field VS is nonzero. When VS is 0 the spacing is 0, so every vectored trap goes to the entry base.
- R5: A strobed exception that is not a refill and not a debug trap goes to base + code * spacing. It saves the privilege level and interrupt enable into the previous mode, records the code and subcode, and saves `pc_i` as the return address. A code 0x00 strobe outside debug state takes the R3 path, with v = 0 when no enabled bit is pending.
- R6: Every accepted trap sets the privilege level to 0 and the interrupt enable to 0 from the next cycle on. `trap_taken_o` and `next_pc_o` are valid in the same cycle as the request.
- R7: Codes 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x10 and 0x12 load the bad-address register with `pc_i`. All other traps leave it unchanged.
- R8: Strobed exceptions load the bad-instruction register with `instr_i`. The exceptions are codes 0x00, 0x03 and 0x08, interrupts and debug traps, which leave it unchanged.
- R9: A strobed exception with `refill_i` = 1 (code neither 0x00 nor 0x1A) saves the privilege level and enable into the refill previous mode. It sets direct-address mode to 1 and paged mode to 0, stores `pc_i` >> 2 in the refill return register and jumps to the refill entry. The normal previous mode, return address and cause stay unchanged.
- R10: Code 0x1A sets the debug-latched bit, writes 0x0C into the debug cause, saves `pc_i` into the debug return register, sets the debug state and jumps to base + 0x480.
- R11: A code 0x00 strobe while the debug state is 1 sets the debug-interrupt bit, saves `pc_i` into the debug return register and jumps to base + 0x480.
- R12: After reset the privilege level is 0, interrupts are disabled, direct-address mode is 1, paged mode is 0, VS and the mask are 0, all pending bits are 0, and `next_pc_o` is 0x1C000000 in the first cycle.
- R13: A control write takes effect from the next cycle, and is ignored in a cycle where a trap is accepted. The select field picks the target: 0 = mode (bits 1:0 privilege, 2 enable, 3 direct, 4 paged), 1 = configuration (bits 12:0 mask, bits 18:16 VS), 2 = entry base, 3 = refill entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| irq_i | input | NIRQ | Interrupt line levels |
| exc_valid_i | input | 1 | Synchronous exception strobe |
| exc_code_i | input | 6 | Exception cause code |
| exc_sub_i | input | 9 | Exception subcode |
| pc_i | input | XLEN | PC of the current instruction |
| instr_i | input | XLEN | Instruction word at pc_i |
| refill_i | input | 1 | Exception is a translation refill |
| ctl_we_i | input | 1 | Control write enable |
| ctl_sel_i | input | 2 | Control write target |
| ctl_wdata_i | input | XLEN | Control write data |
| trap_taken_o | output | 1 | Trap accepted this cycle |
| next_pc_o | output | XLEN | Next fetch address |
| hw_irq_req_o | output | 1 | Some pending bit is set |
| cur_plv_o | output | 2 | Current privilege level |
| cur_ie_o | output | 1 | Current interrupt enable |
| cur_da_o | output | 1 | Direct-address mode |
| cur_pg_o | output | 1 | Paged mode |
| prev_plv_o | output | 2 | Saved privilege level |
| prev_ie_o | output | 1 | Saved interrupt enable |
| era_o | output | XLEN | Trap return address |
| badv_o | output | XLEN | Bad address |
| badi_o | output | XLEN | Bad instruction |
| ecode_o | output | 6 | Recorded cause |
| esub_o | output | 9 | Recorded subcode |
| pending_o | output | NIRQ | Pending interrupt bits |
| dbg_state_o | output | 1 | Debug state |
| dbg_latch_o | output | 1 | Debug cause latched |
| dbg_int_o | output | 1 | Interrupt seen in debug state |
| dbg_code_o | output | 6 | Debug cause |
| dbg_era_o | output | XLEN | Debug return address |
| rf_prev_plv_o | output | 2 | Refill saved privilege level |
| rf_prev_ie_o | output | 1 | Refill saved interrupt enable |
| rf_era_o | output | XLEN-2 | Refill return address (word index) |

## Verification
The properties assume that `exc_valid_i` is a strobe whose code, subcode, PC and refill flag stay stable within the cycle. They also assume that the debug state is left only through reset, since nothing in this block clears it. The stimulus changes inputs only on the falling clock edge and pulses each exception for one cycle. The debug traps come last in the run, so the property that blocks interrupts during debug state is reached without a way out of it. One deliberate control write is placed on a trap cycle to show that it is dropped, and all other writes fall on quiet cycles.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CODE_W = 6;
    localparam int SUB_W  = 9;
    localparam int CIDX_W = 8;

    localparam logic [CODE_W-1:0] C_INT        = 6'h00;
    localparam logic [CODE_W-1:0] C_FETCH_PAGE = 6'h03;
    localparam logic [CODE_W-1:0] C_FETCH_ADDR = 6'h08;
    localparam logic [CODE_W-1:0] C_SYSCALL    = 6'h0B;
    localparam logic [CODE_W-1:0] C_BREAK      = 6'h0C;
    localparam logic [CODE_W-1:0] C_ILLEGAL    = 6'h0D;
    localparam logic [CODE_W-1:0] C_PRIV       = 6'h0E;
    localparam logic [CODE_W-1:0] C_FP_OFF     = 6'h0F;
    localparam logic [CODE_W-1:0] C_VEC_OFF    = 6'h10;
    localparam logic [CODE_W-1:0] C_FP_EXC     = 6'h12;
    localparam logic [CODE_W-1:0] C_DEBUG_BP   = 6'h1A;
    localparam logic [CODE_W-1:0] DBG_CAUSE    = 6'h0C;

    typedef struct packed {
        logic [1:0] plv;
        logic       ie;
        logic       da;
        logic       pg;
    } mode_t;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_CFG    = 2'd1,
        SEL_BASE   = 2'd2,
        SEL_REFILL = 2'd3
    } ctl_sel_e;
endpackage

// File: rtl/trap_cause_class.sv
module trap_cause_class
    import trap_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              is_int_o,
    output logic              is_bp_o,
    output logic              grab_badv_o,
    output logic              grab_badi_o
);
    always_comb begin
        is_int_o = (code_i == C_INT);
        is_bp_o  = (code_i == C_DEBUG_BP);
        case (code_i)
            C_SYSCALL, C_BREAK, C_ILLEGAL, C_PRIV,
            C_FP_OFF, C_VEC_OFF, C_FP_EXC: grab_badv_o = 1'b1;
            default:                       grab_badv_o = 1'b0;
        endcase
        case (code_i)
            C_INT, C_FETCH_PAGE, C_FETCH_ADDR, C_DEBUG_BP: grab_badi_o = 1'b0;
            default:                                       grab_badi_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
    parameter int N     = 13,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     pend_i,
    input  logic [N-1:0]     mask_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N-1:0] live;

    assign live  = pend_i & mask_i;
    assign any_o = |live;

    // Ascending scan: the last set bit seen is the highest-numbered one.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (live[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/trap_target_calc.sv
module trap_target_calc #(
    parameter int XLEN   = 32,
    parameter int VS_W   = 3,
    parameter int CIDX_W = 8
) (
    input  logic [XLEN-1:0]   base_i,
    input  logic [VS_W-1:0]   vs_i,
    input  logic [CIDX_W-1:0] cidx_i,
    output logic [XLEN-1:0]   target_o
);
    logic [XLEN-1:0] offset;

    always_comb begin
        if (vs_i == '0) begin
            offset = '0;
        end else begin
            offset = XLEN'(cidx_i) << (int'(vs_i) + 2);
        end
        target_o = base_i + offset;
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              NIRQ         = 13,
    parameter int              VS_W         = 3,
    parameter int              EXT_INT_BASE = 64,
    parameter logic [XLEN-1:0] BOOT_PC      = 32'h1C00_0000,
    parameter logic [XLEN-1:0] DBG_OFFSET   = 32'h0000_0480
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NIRQ-1:0]     irq_i,
    input  logic                exc_valid_i,
    input  logic [CODE_W-1:0]   exc_code_i,
    input  logic [SUB_W-1:0]    exc_sub_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     instr_i,
    input  logic                refill_i,
    input  logic                ctl_we_i,
    input  logic [1:0]          ctl_sel_i,
    input  logic [XLEN-1:0]     ctl_wdata_i,
    output logic                trap_taken_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                hw_irq_req_o,
    output logic [1:0]          cur_plv_o,
    output logic                cur_ie_o,
    output logic                cur_da_o,
    output logic                cur_pg_o,
    output logic [1:0]          prev_plv_o,
    output logic                prev_ie_o,
    output logic [XLEN-1:0]     era_o,
    output logic [XLEN-1:0]     badv_o,
    output logic [XLEN-1:0]     badi_o,
    output logic [CODE_W-1:0]   ecode_o,
    output logic [SUB_W-1:0]    esub_o,
    output logic [NIRQ-1:0]     pending_o,
    output logic                dbg_state_o,
    output logic                dbg_latch_o,
    output logic                dbg_int_o,
    output logic [CODE_W-1:0]   dbg_code_o,
    output logic [XLEN-1:0]     dbg_era_o,
    output logic [1:0]          rf_prev_plv_o,
    output logic                rf_prev_ie_o,
    output logic [XLEN-3:0]     rf_era_o
);
    localparam int VIDX_W  = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam int VS_LSB  = 16;

    typedef struct packed {
        mode_t               mode;
        logic [1:0]          pplv;
        logic                pie;
        logic [XLEN-1:0]     era;
        logic [XLEN-1:0]     badv;
        logic [XLEN-1:0]     badi;
        logic [CODE_W-1:0]   ecode;
        logic [SUB_W-1:0]    esub;
        logic [NIRQ-1:0]     pend;
        logic [NIRQ-1:0]     mask;
        logic [VS_W-1:0]     vs;
        logic [XLEN-1:0]     base;
        logic [XLEN-1:0]     rentry;
        logic [1:0]          rplv;
        logic                rie;
        logic [XLEN-3:0]     rera;
        logic                dst;
        logic                dcl;
        logic                dei;
        logic [CODE_W-1:0]   dcode;
        logic [XLEN-1:0]     dera;
        logic                boot;
    } st_t;

    st_t s_q, s_d;

    logic              cls_int, cls_bp, cls_badv, cls_badi;
    logic              irq_any;
    logic [VIDX_W-1:0] irq_idx;
    logic [CIDX_W-1:0] cidx;
    logic [XLEN-1:0]   vec_target;

    logic take_exc, take_int, int_class, bp_trap, dbg_int_trap, use_refill, trap;

    trap_cause_class u_class (
        .code_i      (exc_code_i),
        .is_int_o    (cls_int),
        .is_bp_o     (cls_bp),
        .grab_badv_o (cls_badv),
        .grab_badi_o (cls_badi)
    );

    trap_irq_pick #(.N(NIRQ), .IDX_W(VIDX_W)) u_pick (
        .pend_i (s_q.pend),
        .mask_i (s_q.mask),
        .any_o  (irq_any),
        .idx_o  (irq_idx)
    );

    assign cidx = int_class ? (CIDX_W'(EXT_INT_BASE) + CIDX_W'(irq_idx))
                            : CIDX_W'(exc_code_i);

    trap_target_calc #(.XLEN(XLEN), .VS_W(VS_W), .CIDX_W(CIDX_W)) u_target (
        .base_i   (s_q.base),
        .vs_i     (s_q.vs),
        .cidx_i   (cidx),
        .target_o (vec_target)
    );

    // Trap arbitration: a strobed exception always wins over an interrupt.
    always_comb begin
        take_exc     = exc_valid_i;
        take_int     = !exc_valid_i && s_q.mode.ie && !s_q.dst && irq_any;
        trap         = take_exc || take_int;
        int_class    = take_int || (take_exc && cls_int);
        bp_trap      = take_exc && cls_bp;
        dbg_int_trap = int_class && s_q.dst;
        use_refill   = take_exc && refill_i && !cls_int && !cls_bp;
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = irq_i;
        s_d.boot = 1'b0;

        if (bp_trap || dbg_int_trap) begin
            next_pc_o = s_q.base + DBG_OFFSET;
        end else if (use_refill) begin
            next_pc_o = s_q.rentry;
        end else if (trap) begin
            next_pc_o = vec_target;
        end else if (s_q.boot) begin
            next_pc_o = BOOT_PC;
        end else begin
            next_pc_o = pc_i;
        end

        if (trap) begin
            if (bp_trap) begin
                s_d.dcl   = 1'b1;
                s_d.dcode = DBG_CAUSE;
                s_d.dera  = pc_i;
                s_d.dst   = 1'b1;
            end else if (dbg_int_trap) begin
                s_d.dei  = 1'b1;
                s_d.dera = pc_i;
            end else begin
                if (take_exc && cls_badv) begin
                    s_d.badv = pc_i;
                end
                if (take_exc && cls_badi) begin
                    s_d.badi = instr_i;
                end
                if (use_refill) begin
                    s_d.rplv    = s_q.mode.plv;
                    s_d.rie     = s_q.mode.ie;
                    s_d.mode.da = 1'b1;
                    s_d.mode.pg = 1'b0;
                    s_d.rera    = pc_i[XLEN-1:2];
                end else begin
                    s_d.pplv  = s_q.mode.plv;
                    s_d.pie   = s_q.mode.ie;
                    s_d.era   = pc_i;
                    s_d.ecode = int_class ? C_INT : exc_code_i;
                    s_d.esub  = int_class ? '0 : exc_sub_i;
                end
            end
            s_d.mode.plv = 2'd0;
            s_d.mode.ie  = 1'b0;
        end else if (ctl_we_i) begin
            case (ctl_sel_e'(ctl_sel_i))
                SEL_MODE: begin
                    s_d.mode.plv = ctl_wdata_i[1:0];
                    s_d.mode.ie  = ctl_wdata_i[2];
                    s_d.mode.da  = ctl_wdata_i[3];
                    s_d.mode.pg  = ctl_wdata_i[4];
                end
                SEL_CFG: begin
                    s_d.mask = ctl_wdata_i[NIRQ-1:0];
                    s_d.vs   = ctl_wdata_i[VS_LSB +: VS_W];
                end
                SEL_BASE:   s_d.base   = ctl_wdata_i;
                SEL_REFILL: s_d.rentry = ctl_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q         <= '0;
            s_q.mode.da <= 1'b1;
            s_q.boot    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign trap_taken_o  = trap;
    assign hw_irq_req_o  = |s_q.pend;
    assign cur_plv_o     = s_q.mode.plv;
    assign cur_ie_o      = s_q.mode.ie;
    assign cur_da_o      = s_q.mode.da;
    assign cur_pg_o      = s_q.mode.pg;
    assign prev_plv_o    = s_q.pplv;
    assign prev_ie_o     = s_q.pie;
    assign era_o         = s_q.era;
    assign badv_o        = s_q.badv;
    assign badi_o        = s_q.badi;
    assign ecode_o       = s_q.ecode;
    assign esub_o        = s_q.esub;
    assign pending_o     = s_q.pend;
    assign dbg_state_o   = s_q.dst;
    assign dbg_latch_o   = s_q.dcl;
    assign dbg_int_o     = s_q.dei;
    assign dbg_code_o    = s_q.dcode;
    assign dbg_era_o     = s_q.dera;
    assign rf_prev_plv_o = s_q.rplv;
    assign rf_prev_ie_o  = s_q.rie;
    assign rf_era_o      = s_q.rera;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NIRQ = 13
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NIRQ-1:0]   irq_i,
    input logic              exc_valid_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic [XLEN-1:0]   pc_i,
    input logic              refill_i,
    input logic              trap_taken_o,
    input logic [1:0]        cur_plv_o,
    input logic              cur_ie_o,
    input logic              cur_da_o,
    input logic              cur_pg_o,
    input logic [XLEN-1:0]   era_o,
    input logic [NIRQ-1:0]   pending_o,
    input logic              dbg_state_o,
    input logic              dbg_latch_o
);
    a_r1_pending_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (pending_o == $past(irq_i)));

    a_r2_no_int_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exc_valid_i && !cur_ie_o) |-> !trap_taken_o);

    a_r2_no_int_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exc_valid_i && dbg_state_o) |-> !trap_taken_o);

    a_r6_mode_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_taken_o |=> (cur_plv_o == 2'd0 && !cur_ie_o));

    a_r6_strobe_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_valid_i |-> trap_taken_o);

    a_r9_refill_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && refill_i && exc_code_i != C_INT && exc_code_i != C_DEBUG_BP)
        |=> (cur_da_o && !cur_pg_o));

    a_r5_return_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && !refill_i && exc_code_i != C_INT && exc_code_i != C_DEBUG_BP)
        |=> (era_o == $past(pc_i)));

    a_r10_enter_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && exc_code_i == C_DEBUG_BP) |=> (dbg_state_o && dbg_latch_o));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
    localparam int XLEN = 32;
    localparam int NIRQ = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic            exc_valid = 1'b0;
    logic [5:0]      exc_code = '0;
    logic [8:0]      exc_sub = '0;
    logic [31:0]     pc = '0;
    logic [31:0]     instr = '0;
    logic            refill = 1'b0;
    logic            ctl_we = 1'b0;
    logic [1:0]      ctl_sel = '0;
    logic [31:0]     ctl_wdata = '0;

    logic            trap_taken, hw_req, cur_ie, cur_da, cur_pg, prev_ie;
    logic [31:0]     next_pc, era, badv, badi, dbg_era;
    logic [1:0]      cur_plv, prev_plv, rf_plv;
    logic [5:0]      ecode, dbg_code;
    logic [8:0]      esub;
    logic [NIRQ-1:0] pending;
    logic            dbg_state, dbg_latch, dbg_int, rf_ie;
    logic [29:0]     rf_era;

    trap_entry_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .exc_valid_i(exc_valid),
        .exc_code_i(exc_code), .exc_sub_i(exc_sub), .pc_i(pc), .instr_i(instr),
        .refill_i(refill), .ctl_we_i(ctl_we), .ctl_sel_i(ctl_sel), .ctl_wdata_i(ctl_wdata),
        .trap_taken_o(trap_taken), .next_pc_o(next_pc), .hw_irq_req_o(hw_req),
        .cur_plv_o(cur_plv), .cur_ie_o(cur_ie), .cur_da_o(cur_da), .cur_pg_o(cur_pg),
        .prev_plv_o(prev_plv), .prev_ie_o(prev_ie), .era_o(era), .badv_o(badv),
        .badi_o(badi), .ecode_o(ecode), .esub_o(esub), .pending_o(pending),
        .dbg_state_o(dbg_state), .dbg_latch_o(dbg_latch), .dbg_int_o(dbg_int),
        .dbg_code_o(dbg_code), .dbg_era_o(dbg_era), .rf_prev_plv_o(rf_plv),
        .rf_prev_ie_o(rf_ie), .rf_era_o(rf_era)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    logic [1:0]  m_plv, m_pplv, m_rplv;
    logic        m_ie, m_da, m_pg, m_pie, m_rie, m_dst, m_dcl, m_dei, m_boot;
    logic [31:0] m_era, m_badv, m_badi, m_base, m_rentry, m_dera;
    logic [5:0]  m_ecode, m_dcode;
    logic [8:0]  m_esub;
    logic [NIRQ-1:0] m_pend, m_mask;
    logic [2:0]  m_vs;
    logic [29:0] m_rera;

    task automatic model_reset();
        m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0; m_pplv = 0; m_pie = 0;
        m_era = 0; m_badv = 0; m_badi = 0; m_ecode = 0; m_esub = 0;
        m_pend = 0; m_mask = 0; m_vs = 0; m_base = 0; m_rentry = 0;
        m_rplv = 0; m_rie = 0; m_rera = 0; m_dst = 0; m_dcl = 0; m_dei = 0;
        m_dcode = 0; m_dera = 0; m_boot = 1;
    endtask

    function automatic logic int_ready();
        return m_ie && !m_dst && ((m_pend & m_mask) != 0);
    endfunction

    function automatic int top_vector();
        int v = 0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (m_pend[i] && m_mask[i]) begin
                v = i;
                break;
            end
        end
        return v;
    endfunction

    function automatic logic [31:0] spacing();
        if (m_vs == 0) return 32'd0;
        return 32'd4 * (32'd1 << m_vs);
    endfunction

    function automatic logic exp_taken();
        return exc_valid || int_ready();
    endfunction

    function automatic logic is_int_class();
        return (exc_valid && exc_code == 6'h00) || (!exc_valid && int_ready());
    endfunction

    function automatic logic [31:0] exp_pc();
        if (!exp_taken()) return m_boot ? 32'h1C00_0000 : pc;
        if ((exc_valid && exc_code == 6'h1A) || (is_int_class() && m_dst))
            return m_base + 32'h480;
        if (exc_valid && refill && exc_code != 6'h00) return m_rentry;
        if (is_int_class()) return m_base + (32'd64 + 32'(top_vector())) * spacing();
        return m_base + 32'(exc_code) * spacing();
    endfunction

    task automatic model_update();
        logic intc;
        intc = is_int_class();
        if (exp_taken()) begin
            if (exc_valid && exc_code == 6'h1A) begin
                m_dcl = 1; m_dcode = 6'h0C; m_dera = pc; m_dst = 1;
            end else if (intc && m_dst) begin
                m_dei = 1; m_dera = pc;
            end else begin
                if (exc_valid && (exc_code inside {6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h10, 6'h12}))
                    m_badv = pc;
                if (exc_valid && !(exc_code inside {6'h00, 6'h03, 6'h08}))
                    m_badi = instr;
                if (exc_valid && refill && exc_code != 6'h00) begin
                    m_rplv = m_plv; m_rie = m_ie; m_da = 1; m_pg = 0; m_rera = pc >> 2;
                end else begin
                    m_pplv = m_plv; m_pie = m_ie; m_era = pc;
                    m_ecode = intc ? 6'h00 : exc_code;
                    m_esub  = intc ? 9'h000 : exc_sub;
                end
            end
            m_plv = 0; m_ie = 0;
        end else if (ctl_we) begin
            case (ctl_sel)
                2'd0: begin
                    m_plv = ctl_wdata[1:0]; m_ie = ctl_wdata[2];
                    m_da = ctl_wdata[3]; m_pg = ctl_wdata[4];
                end
                2'd1: begin m_mask = ctl_wdata[12:0]; m_vs = ctl_wdata[18:16]; end
                2'd2: m_base = ctl_wdata;
                default: m_rentry = ctl_wdata;
            endcase
        end
        m_pend = irq;
        m_boot = 0;
    endtask

    task automatic step(input string tag);
        logic [255:0] got, want;
        #3;
        checks++;
        if (trap_taken !== exp_taken() || next_pc !== exp_pc()) begin
            fails++;
            $display("FAIL %s trap/pc: got %b/%h expected %b/%h",
                     tag, trap_taken, next_pc, exp_taken(), exp_pc());
        end
        got  = {cur_plv, cur_ie, cur_da, cur_pg, prev_plv, prev_ie, era, badv, badi,
                ecode, esub, pending, hw_req, dbg_state, dbg_latch, dbg_int, dbg_code,
                dbg_era, rf_plv, rf_ie, rf_era};
        want = {m_plv, m_ie, m_da, m_pg, m_pplv, m_pie, m_era, m_badv, m_badi,
                m_ecode, m_esub, m_pend, (m_pend != 0), m_dst, m_dcl, m_dei, m_dcode,
                m_dera, m_rplv, m_rie, m_rera};
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s state: got %h expected %h", tag, got, want);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        exc_valid = 0; refill = 0; ctl_we = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
        ctl_we = 1; ctl_sel = sel; ctl_wdata = d;
        step(tag);
    endtask

    task automatic ex(input logic [5:0] c, input logic [8:0] s, input logic [31:0] p,
                      input logic [31:0] ins, input logic rf, input string tag);
        exc_valid = 1; exc_code = c; exc_sub = s; pc = p; instr = ins; refill = rf;
        step(tag);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: got hung run expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        pc = 32'h0000_0100;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R12 boot");
        step("R12 after boot");
        wr(2'd2, 32'h8000_0000, "R13 base");
        wr(2'd3, 32'h9000_0000, "R13 refill entry");
        wr(2'd1, 32'h0001_00FF, "R13 cfg");
        wr(2'd0, 32'h0000_0013, "R13 mode");
        step("R13 mode applied");
        ex(6'h0B, 9'h005, 32'h0000_1000, 32'h0000_DEAD, 0, "R5 R6 R7 R8 syscall");
        step("R6 R7 R8 after syscall");
        wr(2'd1, 32'h0000_00FF, "R4 vs zero");
        ex(6'h12, 9'h001, 32'h0000_2000, 32'h0000_1111, 0, "R4 R7 fp exc");
        wr(2'd1, 32'h0003_00FF, "R4 vs three");
        ex(6'h03, 9'h002, 32'h0000_3000, 32'h0000_BEEF, 0, "R7 R8 fetch page");
        ex(6'h08, 9'h000, 32'h0000_3100, 32'h0000_BEE0, 0, "R8 fetch addr");
        ex(6'h22, 9'h0AA, 32'h0000_3200, 32'h0000_C0DE, 0, "R5 R7 generic");
        wr(2'd0, 32'h0000_0016, "R13 mode plv2 ie");
        ex(6'h01, 9'h000, 32'h0000_4004, 32'h0000_7777, 1, "R9 refill");
        step("R9 after refill");
        ctl_we = 1; ctl_sel = 2'd0; ctl_wdata = 32'h0000_0003;
        ex(6'h0D, 9'h000, 32'h0000_4100, 32'h0000_2222, 0, "R13 write dropped");
        step("R13 R6 after dropped write");
        irq = 13'h0088;
        step("R1 lines set");
        step("R1 R2 pending ie off");
        wr(2'd1, 32'h0002_007F, "R3 cfg mask");
        wr(2'd0, 32'h0000_000C, "R2 enable");
        pc = 32'h0000_5000;
        step("R2 R3 interrupt vec3");
        step("R6 after interrupt");
        wr(2'd0, 32'h0000_0004, "R2 enable again");
        ex(6'h0C, 9'h003, 32'h0000_5100, 32'h0000_3333, 0, "R2 exception wins");
        wr(2'd1, 32'h0001_1FFF, "R3 full mask");
        wr(2'd0, 32'h0000_0004, "R3 enable");
        step("R3 interrupt vec7");
        ex(6'h00, 9'h000, 32'h0000_5200, 32'h0000_4444, 0, "R5 code0 strobe");
        irq = 13'h0000;
        step("R1 lines clear");
        step("R1 pending clear");
        ex(6'h1A, 9'h000, 32'h0000_6000, 32'h0000_5555, 0, "R10 breakpoint");
        step("R10 debug state");
        irq = 13'h0010;
        wr(2'd0, 32'h0000_0004, "R2 enable in debug");
        step("R2 no interrupt in debug");
        step("R2 still none");
        ex(6'h00, 9'h000, 32'h0000_7000, 32'h0000_6666, 0, "R11 debug interrupt");
        step("R11 after debug interrupt");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule